// File: doc/BRIEF.md
# Packed SIMD Shift and Compare Unit

This unit works on a 64-bit packed operand. It either shifts every lane by a single shared unsigned amount, or it compares four signed 16-bit lanes of two operands and returns the results as a bit mask. A 4-bit opcode picks the operation and the lane width. The lanes can be two 32-bit words or four 16-bit halfwords. A narrow variant shifts only the two halfwords of the low 32 bits to the left. Shifting is kept inside each lane, so no bit passes from one lane into the next.

The unit takes one operation per cycle. The result is registered and is marked by a valid strobe one cycle after the request. The result stays unchanged until the next accepted request.

Top module: `simd_shcmp_unit`

## Requirements
- R1: When `in_valid` is high at a rising edge, `out_valid` is high during the following cycle and `result` holds the new value. When `in_valid` is low at an edge, `out_valid` is low in the following cycle.
- R2: Reset (`rst_n` low, asynchronous) clears `result` and `out_valid`. While `in_valid` is low, `result` keeps its last value.
- R3: Word mode works on lanes bits 31:0 and 63:32. Opcode 0 is the arithmetic right shift, opcode 1 is the logical right shift and opcode 2 is the left shift. Each lane is shifted on its own by `shamt`.
- R4: Halfword mode works on four 16-bit lanes, with lane i at bits 16i+15:16i. Opcode 3 is the arithmetic right shift, opcode 4 is the logical right shift and opcode 5 is the left shift, each applied per lane.
- R5: If `shamt` is equal to or larger than the lane width, the left and logical shifts return zero for that lane. The arithmetic right shift fills the lane with copies of the lane's sign bit.
- R6: Opcode 6 shifts the two halfwords in `src_a[31:0]` left by `shamt`, each on its own. `result[63:32]` is zero.
- R7: Opcode 7 sets `result[i]` when halfword lane i of `src_a` is greater than lane i of `src_b`, both read as signed values. Opcode 8 sets `result[i]` when the two lanes are equal.
- R8: For the compare opcodes 7 and 8, `result[63:4]` is zero.
- R9: Opcodes 9 through 15 are reserved. They return an all-zero result and still raise `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| opcode | input | 4 | Operation select (see R3 to R9) |
| src_a | input | 64 | Data operand, shifted or compared |
| src_b | input | 64 | Second compare operand |
| shamt | input | 6 | Unsigned shift amount shared by all lanes |
| out_valid | output | 1 | Result valid strobe |
| result | output | 64 | Registered result |

## Verification
On every cycle, the assertions check the following:
- the valid timing and the holding of the result;
- the zero upper bits of compare masks and of narrow shifts;
- saturation at oversized shift amounts;
- that equal operands give a full equality mask.

Bit-exact shift values per lane, including the absence of bit leakage across lane boundaries, are shown only by the bench's sweeps. The same holds for the signed ordering of greater-than on sign-boundary values. Those sweeps cover every shift amount from 0 to 63 on varied data patterns.

// File: rtl/simd_shcmp_pkg.sv
package simd_shcmp_pkg;

  localparam logic [3:0] OP_SRA_W   = 4'd0;
  localparam logic [3:0] OP_SRL_W   = 4'd1;
  localparam logic [3:0] OP_SLL_W   = 4'd2;
  localparam logic [3:0] OP_SRA_H   = 4'd3;
  localparam logic [3:0] OP_SRL_H   = 4'd4;
  localparam logic [3:0] OP_SLL_H   = 4'd5;
  localparam logic [3:0] OP_SLL_HN  = 4'd6;
  localparam logic [3:0] OP_CMPGT_H = 4'd7;
  localparam logic [3:0] OP_CMPEQ_H = 4'd8;

  typedef enum logic [1:0] {
    SK_ARITH = 2'd0,
    SK_LOGIC = 2'd1,
    SK_LEFT  = 2'd2
  } shkind_e;

  function automatic shkind_e kind_of(input logic [3:0] op);
    case (op)
      OP_SRA_W, OP_SRA_H: return SK_ARITH;
      OP_SRL_W, OP_SRL_H: return SK_LOGIC;
      default:            return SK_LEFT;
    endcase
  endfunction

endpackage

// File: rtl/simd_lane_shifter.sv
module simd_lane_shifter
  import simd_shcmp_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LANE_W = 32,
  parameter int SHW    = 6
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [SHW-1:0]    amt_i,
  input  shkind_e           kind_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int NLANE = DATA_W / LANE_W;

  // amount reaches or passes the lane width
  logic amt_over;
  assign amt_over = ({{(32-SHW){1'b0}}, amt_i} >= 32'(LANE_W));

  function automatic logic [LANE_W-1:0] lane_op(
    input logic [LANE_W-1:0] v,
    input logic [SHW-1:0]    n,
    input shkind_e           k,
    input logic              over
  );
    if (over) return (k == SK_ARITH) ? {LANE_W{v[LANE_W-1]}} : '0;
    case (k)
      SK_ARITH: return $signed(v) >>> n;
      SK_LOGIC: return v >> n;
      default:  return v << n;
    endcase
  endfunction

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign data_o[g*LANE_W +: LANE_W] =
      lane_op(data_i[g*LANE_W +: LANE_W], amt_i, kind_i, amt_over);
  end

endmodule

// File: rtl/simd_lane_compare.sv
module simd_lane_compare #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 16,
  localparam int NLANE = DATA_W / LANE_W
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [NLANE-1:0]  gt_o,
  output logic [NLANE-1:0]  eq_o
);
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic signed [LANE_W-1:0] la, lb;
    assign la = a_i[g*LANE_W +: LANE_W];
    assign lb = b_i[g*LANE_W +: LANE_W];
    assign gt_o[g] = (la > lb);
    assign eq_o[g] = (la == lb);
  end
endmodule

// File: rtl/simd_shcmp_unit.sv
module simd_shcmp_unit
  import simd_shcmp_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SHW    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        opcode,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [SHW-1:0]    shamt,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;
  localparam int NHALF  = DATA_W / HALF_W;

  shkind_e           kind;
  logic [DATA_W-1:0] half_src;
  logic [DATA_W-1:0] word_res;
  logic [DATA_W-1:0] half_res;
  logic [NHALF-1:0]  gt_mask;
  logic [NHALF-1:0]  eq_mask;
  logic [DATA_W-1:0] next_res;

  assign kind     = kind_of(opcode);
  assign half_src = (opcode == OP_SLL_HN) ?
                    {{(DATA_W-WORD_W){1'b0}}, src_a[WORD_W-1:0]} : src_a;

  simd_lane_shifter #(.DATA_W(DATA_W), .LANE_W(WORD_W), .SHW(SHW)) u_word (
    .data_i(src_a), .amt_i(shamt), .kind_i(kind), .data_o(word_res)
  );

  simd_lane_shifter #(.DATA_W(DATA_W), .LANE_W(HALF_W), .SHW(SHW)) u_half (
    .data_i(half_src), .amt_i(shamt), .kind_i(kind), .data_o(half_res)
  );

  simd_lane_compare #(.DATA_W(DATA_W), .LANE_W(HALF_W)) u_cmp (
    .a_i(src_a), .b_i(src_b), .gt_o(gt_mask), .eq_o(eq_mask)
  );

  always_comb begin
    case (opcode)
      OP_SRA_W, OP_SRL_W, OP_SLL_W:            next_res = word_res;
      OP_SRA_H, OP_SRL_H, OP_SLL_H, OP_SLL_HN: next_res = half_res;
      OP_CMPGT_H: next_res = {{(DATA_W-NHALF){1'b0}}, gt_mask};
      OP_CMPEQ_H: next_res = {{(DATA_W-NHALF){1'b0}}, eq_mask};
      default:    next_res = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_res;
    end
  end

endmodule

// File: rtl/simd_shcmp_checker.sv
module simd_shcmp_checker
  import simd_shcmp_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SHW    = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [3:0]        opcode,
  input logic [DATA_W-1:0] src_a,
  input logic [DATA_W-1:0] src_b,
  input logic [SHW-1:0]    shamt,
  input logic              out_valid,
  input logic [DATA_W-1:0] result
);
  logic is_cmp;
  assign is_cmp = (opcode == OP_CMPGT_H) || (opcode == OP_CMPEQ_H);

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R1
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result)); // R2
  AST_SLL_OVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == OP_SLL_W && shamt >= SHW'(32)) |=> result == '0); // R5
  AST_SRA_OVER_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == OP_SRA_W && shamt >= SHW'(32)) |=>
      result[31:0] == {32{$past(src_a[31])}}); // R5
  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == OP_SLL_HN) |=> result[DATA_W-1:32] == '0); // R6
  AST_EQ_SELF_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == OP_CMPEQ_H && src_a == src_b) |=> result[3:0] == 4'hF); // R7
  AST_MASK_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_cmp) |=> result[DATA_W-1:4] == '0); // R8
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode > OP_CMPEQ_H) |=> result == '0); // R9

endmodule

bind simd_shcmp_unit simd_shcmp_checker #(.DATA_W(DATA_W), .SHW(SHW)) u_chk (.*);

// File: tb/tb_simd_shcmp_unit.sv
`timescale 1ns/1ps
module tb_simd_shcmp_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  opcode = '0;
  logic [63:0] src_a = '0;
  logic [63:0] src_b = '0;
  logic [5:0]  shamt = '0;
  logic        out_valid;
  logic [63:0] result;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  simd_shcmp_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .src_a(src_a), .src_b(src_b), .shamt(shamt),
    .out_valid(out_valid), .result(result)
  );

  // kind: 0 arithmetic right, 1 logical right, 2 left; bit-by-bit reference
  function automatic logic [31:0] ref_lane(logic [31:0] v, int w, int amt, int kind);
    logic [31:0] r = '0;
    for (int j = 0; j < w; j++) begin
      int s;
      s = (kind == 2) ? j - amt : j + amt;
      if (s >= 0 && s < w) r[j] = v[s];
      else r[j] = (kind == 0) ? v[w-1] : 1'b0;
    end
    return r;
  endfunction

  function automatic logic [63:0] model(int op, logic [63:0] a, logic [63:0] b, int amt);
    logic [63:0] r = '0;
    if (op <= 2) begin
      for (int l = 0; l < 2; l++) r[32*l +: 32] = ref_lane(a[32*l +: 32], 32, amt, op);
    end else if (op <= 5) begin
      for (int l = 0; l < 4; l++) r[16*l +: 16] = ref_lane({16'h0, a[16*l +: 16]}, 16, amt, op - 3)[15:0];
    end else if (op == 6) begin
      for (int l = 0; l < 2; l++) r[16*l +: 16] = ref_lane({16'h0, a[16*l +: 16]}, 16, amt, 2)[15:0];
    end else if (op == 7 || op == 8) begin
      for (int l = 0; l < 4; l++) begin
        int x, y;
        x = int'($signed(a[16*l +: 16]));
        y = int'($signed(b[16*l +: 16]));
        r[l] = (op == 7) ? (x > y) : (x == y);
      end
    end
    return r;
  endfunction

  function automatic string req_of(int op, int amt);
    if (op <= 2) return (amt >= 32) ? "R5" : "R3";
    if (op <= 5) return (amt >= 16) ? "R5" : "R4";
    if (op == 6) return "R6";
    if (op <= 8) return "R7";
    return "R9";
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run_op(int op, logic [63:0] a, logic [63:0] b, int amt);
    logic [63:0] exp;
    logic [63:0] held;
    @(negedge clk);
    in_valid = 1'b1; opcode = 4'(op); src_a = a; src_b = b; shamt = 6'(amt);
    @(negedge clk);
    in_valid = 1'b0;
    exp = model(op, a, b, amt);
    chk(result == exp, req_of(op, amt), result, exp);
    chk(out_valid == 1'b1, "R1", {63'h0, out_valid}, 64'h1);
    if (op == 7 || op == 8) chk(result[63:4] == '0, "R8", result, exp);
    held = result;
    opcode = ~opcode; src_a = ~a; shamt = ~shamt;
    @(negedge clk);
    chk(result == held && !out_valid, "R2", result, held);
  endtask

  logic [63:0] pats [4] = '{64'hF0E1_D2C3_B4A5_9687, 64'h0123_4567_89AB_CDEF,
                            64'h8000_7FFF_0001_FFFF, 64'hFFFF_FFFF_0000_0000};
  logic [15:0] hv [6] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h0005};

  initial begin
    repeat (3) @(negedge clk);
    chk(result == '0 && !out_valid, "R2", result, 64'h0);
    rst_n = 1'b1;
    for (int p = 0; p < 4; p++)
      for (int op = 0; op <= 6; op++)
        for (int amt = 0; amt < 64; amt++)
          run_op(op, pats[p], 64'h0, amt);
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++) begin
        logic [63:0] a, b;
        a = {hv[i], hv[j], hv[(i+1)%6], hv[(j+2)%6]};
        b = {hv[j], hv[i], hv[(i+1)%6], hv[(j+3)%6]};
        run_op(7, a, b, 0);
        run_op(8, a, b, 0);
        run_op(8, a, a, 0);
      end
    for (int op = 9; op < 16; op++) run_op(op, pats[0], pats[1], 3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R1 watchdog act=%h exp=%h", 64'h0, 64'h1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule